// File: doc/BRIEF.md
# SPI Port Status Flags and Interrupt Requests

This block keeps the four status flags of an SPI port and turns them into two interrupt requests. The flags are transmit buffer empty, receive buffer full, receive overflow and mode fault. The shifter reports events as single-cycle strobes. A completed byte and a transmit-buffer load each arrive as a strobe. A mode-fault condition arrives as a level that stays high while the fault exists. The bus decoder reports four kinds of CPU access as strobes: a status read, a control write, a data read and a data write. The flags clear only through the access orderings that software is expected to follow. Each such sequence is tracked by a small armed bit for each flag.

There are two interrupt requests. The transmitter request needs the port enable as well as its own enable. The combined receiver/error request does not look at the port enable. All flags are registered, so a strobe shows on the flag outputs one clock after it is sampled. The interrupt outputs are combinational from the flags and the enable inputs.

Top module: `spi_stat_flags`

## Requirements
- R1: After reset, `txe` is 1, and `rxf`, `ovr` and `mdf` are 0.
- R2: `rx_done` sets `rxf`. `rxf` clears only on a `dat_rd` that follows a `sts_rd` sampled while `rxf` was 1. Any `dat_rd` consumes that arming, and a `dat_rd` with no arming leaves `rxf` unchanged.
- R3: `ovr` sets when `rx_done` is sampled while `rxf` is already 1. It clears with its own armed bit through the same ordering as `rxf`: first `sts_rd` while `ovr` is 1, then `dat_rd`.
- R4: `dat_wr` clears `txe` with no arming needed, and `tx_load` sets `txe`.
- R5: `mdf` is set in every cycle in which `mf_cond` is 1. It clears only on a `ctl_wr` that follows a `sts_rd` sampled while `mdf` was 1. `mf_cond` must be 0 in the cycle of the `sts_rd`, in every cycle after it and in the cycle of the `ctl_wr`. Any `ctl_wr`, and any cycle with `mf_cond` high, cancels the arming.
- R6: When a set event and a completed clearing access fall in the same cycle, the flag ends up 1.
- R7: `irq_tx` is 1 exactly when `txe`, `ie_tx` and `en_spi` are all 1.
- R8: `irq_rxerr` is 1 when (`rxf` and `ie_rx`) or ((`ovr` or `mdf`) and `ie_err`), whatever the value of `en_spi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_spi | input | 1 | Port enable |
| ie_tx | input | 1 | Transmitter interrupt enable |
| ie_rx | input | 1 | Receive-full interrupt enable |
| ie_err | input | 1 | Overflow / mode-fault interrupt enable |
| rx_done | input | 1 | Strobe: a byte was received |
| tx_load | input | 1 | Strobe: transmit buffer moved into the shifter |
| mf_cond | input | 1 | Level: mode-fault condition present |
| sts_rd | input | 1 | Strobe: status register read |
| ctl_wr | input | 1 | Strobe: control register write |
| dat_rd | input | 1 | Strobe: data register read |
| dat_wr | input | 1 | Strobe: data register write |
| txe | output | 1 | Transmit buffer empty flag |
| rxf | output | 1 | Receive buffer full flag |
| ovr | output | 1 | Overflow flag |
| mdf | output | 1 | Mode-fault flag |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_rxerr | output | 1 | Receiver/error interrupt request |

## Verification
An armed bit that is wrong cannot be seen directly. It shows up at the next clearing access: a flag clears when it should not, or stays set, and the flag output shows this one clock after that data read or control write. A flag register that is wrong reaches the interrupt outputs in the same cycle, because the gating has no registers. The bench therefore compares all six outputs in every cycle against a model that follows the access history. Errors caused by an armed bit can be missed only if no clearing access follows them.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  typedef struct packed {
    logic txe;
    logic rxf;
    logic ovr;
    logic mdf;
  } stat_flags_t;

  // next value of a sticky flag: a set event beats a clear
  function automatic logic flag_next(logic cur, logic set_ev, logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

  // armed bit of a clearing sequence
  function automatic logic arm_next(logic armed, logic qual, logic consume, logic hold);
    if (hold || consume) return 1'b0;
    return armed | qual;
  endfunction

  function automatic logic tx_request(stat_flags_t f, logic ie, logic en);
    return f.txe & ie & en;
  endfunction

  function automatic logic rxerr_request(stat_flags_t f, logic ie_rx, logic ie_err);
    return (f.rxf & ie_rx) | ((f.ovr | f.mdf) & ie_err);
  endfunction

endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell
  import spi_stat_pkg::*;
#(
  parameter bit RST_VAL = 1'b0,
  parameter bit SEQ_CLR = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic qual_i,
  input  logic use_i,
  input  logic hold_i,
  output logic flag_o,
  output logic armed_o,
  output logic clr_o
);

  logic flag_q;

  generate
    if (SEQ_CLR) begin : g_seq
      logic arm_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm_next(arm_q, qual_i & flag_q & ~hold_i, use_i, hold_i);
      end
      assign armed_o = arm_q;
      assign clr_o   = use_i & arm_q & ~hold_i;
    end else begin : g_direct
      logic unused_qual;
      assign unused_qual = qual_i;
      assign armed_o     = 1'b0;
      assign clr_o       = use_i & ~hold_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= RST_VAL;
    else        flag_q <= flag_next(flag_q, set_i, clr_o);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate
  import spi_stat_pkg::*;
(
  input  stat_flags_t flags,
  input  logic        en_spi,
  input  logic        ie_tx,
  input  logic        ie_rx,
  input  logic        ie_err,
  output logic        irq_tx,
  output logic        irq_rxerr
);

  assign irq_tx    = tx_request(flags, ie_tx, en_spi);
  assign irq_rxerr = rxerr_request(flags, ie_rx, ie_err);

endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_spi,
  input  logic ie_tx,
  input  logic ie_rx,
  input  logic ie_err,
  input  logic rx_done,
  input  logic tx_load,
  input  logic mf_cond,
  input  logic sts_rd,
  input  logic ctl_wr,
  input  logic dat_rd,
  input  logic dat_wr,
  output logic txe,
  output logic rxf,
  output logic ovr,
  output logic mdf,
  output logic irq_tx,
  output logic irq_rxerr
);

  // named internal events, brought out for the checker
  logic ovr_set_ev;
  logic txe_armed, rxf_armed, ovr_armed, mdf_armed;
  logic txe_clr, rxf_clr, ovr_clr, mdf_clr;
  stat_flags_t flags;

  assign ovr_set_ev = rx_done & rxf;

  spi_flag_cell #(.RST_VAL(1'b1), .SEQ_CLR(1'b0)) u_txe (
    .clk(clk), .rst_n(rst_n), .set_i(tx_load), .qual_i(sts_rd),
    .use_i(dat_wr), .hold_i(1'b0),
    .flag_o(txe), .armed_o(txe_armed), .clr_o(txe_clr)
  );

  spi_flag_cell #(.RST_VAL(1'b0), .SEQ_CLR(1'b1)) u_rxf (
    .clk(clk), .rst_n(rst_n), .set_i(rx_done), .qual_i(sts_rd),
    .use_i(dat_rd), .hold_i(1'b0),
    .flag_o(rxf), .armed_o(rxf_armed), .clr_o(rxf_clr)
  );

  spi_flag_cell #(.RST_VAL(1'b0), .SEQ_CLR(1'b1)) u_ovr (
    .clk(clk), .rst_n(rst_n), .set_i(ovr_set_ev), .qual_i(sts_rd),
    .use_i(dat_rd), .hold_i(1'b0),
    .flag_o(ovr), .armed_o(ovr_armed), .clr_o(ovr_clr)
  );

  spi_flag_cell #(.RST_VAL(1'b0), .SEQ_CLR(1'b1)) u_mdf (
    .clk(clk), .rst_n(rst_n), .set_i(mf_cond), .qual_i(sts_rd),
    .use_i(ctl_wr), .hold_i(mf_cond),
    .flag_o(mdf), .armed_o(mdf_armed), .clr_o(mdf_clr)
  );

  assign flags = '{txe: txe, rxf: rxf, ovr: ovr, mdf: mdf};

  spi_irq_gate u_irq (
    .flags(flags), .en_spi(en_spi), .ie_tx(ie_tx), .ie_rx(ie_rx),
    .ie_err(ie_err), .irq_tx(irq_tx), .irq_rxerr(irq_rxerr)
  );

endmodule

// File: rtl/spi_stat_flags_chk.sv
module spi_stat_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic en_spi,
  input logic ie_tx,
  input logic ie_rx,
  input logic ie_err,
  input logic rx_done,
  input logic tx_load,
  input logic mf_cond,
  input logic ctl_wr,
  input logic dat_rd,
  input logic dat_wr,
  input logic txe,
  input logic rxf,
  input logic ovr,
  input logic mdf,
  input logic irq_tx,
  input logic irq_rxerr,
  input logic rxf_armed,
  input logic ovr_armed,
  input logic mdf_armed
);

  assert_rxf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rxf);

  assert_rxf_clear_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxf) |-> ($past(dat_rd) && $past(rxf_armed)));

  assert_ovr_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($past(rx_done) && $past(rxf)));

  assert_ovr_clear_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> ($past(dat_rd) && $past(ovr_armed)));

  assert_txe_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !tx_load) |=> !txe);

  assert_txe_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> txe);

  assert_mdf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mf_cond |=> (mdf && !mdf_armed));

  assert_mdf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdf) |-> ($past(ctl_wr) && $past(mdf_armed) && !$past(mf_cond)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && dat_rd) |=> rxf);

  assert_tx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_spi || !ie_tx || !txe) |-> !irq_tx);

  assert_rx_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((rxf && ie_rx) || ((ovr || mdf) && ie_err)) |-> irq_rxerr);

endmodule

bind spi_stat_flags spi_stat_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_spi(en_spi), .ie_tx(ie_tx), .ie_rx(ie_rx),
  .ie_err(ie_err), .rx_done(rx_done), .tx_load(tx_load), .mf_cond(mf_cond),
  .ctl_wr(ctl_wr), .dat_rd(dat_rd), .dat_wr(dat_wr),
  .txe(txe), .rxf(rxf), .ovr(ovr), .mdf(mdf), .irq_tx(irq_tx),
  .irq_rxerr(irq_rxerr), .rxf_armed(rxf_armed), .ovr_armed(ovr_armed),
  .mdf_armed(mdf_armed)
);

// File: tb/spi_stat_flags_bench.sv
module spi_stat_flags_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_spi = 1'b0, ie_tx = 1'b0, ie_rx = 1'b0, ie_err = 1'b0;
  logic rx_done = 1'b0, tx_load = 1'b0, mf_cond = 1'b0;
  logic sts_rd = 1'b0, ctl_wr = 1'b0, dat_rd = 1'b0, dat_wr = 1'b0;
  logic txe, rxf, ovr, mdf, irq_tx, irq_rxerr;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // model state: flags and pending clear sequences
  bit m_txe = 1'b1, m_rxf = 1'b0, m_ovr = 1'b0, m_mdf = 1'b0;
  bit p_rxf = 1'b0, p_ovr = 1'b0, p_mdf = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spi_stat_flags u_spi_stat_flags (
    .clk(clk), .rst_n(rst_n), .en_spi(en_spi), .ie_tx(ie_tx), .ie_rx(ie_rx),
    .ie_err(ie_err), .rx_done(rx_done), .tx_load(tx_load), .mf_cond(mf_cond),
    .sts_rd(sts_rd), .ctl_wr(ctl_wr), .dat_rd(dat_rd), .dat_wr(dat_wr),
    .txe(txe), .rxf(rxf), .ovr(ovr), .mdf(mdf), .irq_tx(irq_tx),
    .irq_rxerr(irq_rxerr)
  );

  function automatic bit exp_irq_tx();
    return (en_spi && ie_tx) ? m_txe : 1'b0;
  endfunction

  function automatic bit exp_irq_rxerr();
    bit any_err = m_ovr || m_mdf;
    if (ie_rx && m_rxf) return 1'b1;
    return ie_err ? any_err : 1'b0;
  endfunction

  task automatic chk(input string req, input logic act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // advance the model by one clock with the strobes just driven
  task automatic model_tick();
    bit old_rxf = m_rxf;
    // receive full (R2)
    if (dat_rd) begin
      if (p_rxf) m_rxf = 1'b0;
      p_rxf = 1'b0;
    end else if (sts_rd && old_rxf) p_rxf = 1'b1;
    if (rx_done) m_rxf = 1'b1;
    // overflow (R3)
    if (dat_rd) begin
      if (p_ovr) m_ovr = 1'b0;
      p_ovr = 1'b0;
    end else if (sts_rd && m_ovr) p_ovr = 1'b1;
    if (rx_done && old_rxf) m_ovr = 1'b1;
    // transmit empty (R4)
    if (tx_load) m_txe = 1'b1;
    else if (dat_wr) m_txe = 1'b0;
    // mode fault (R5)
    if (mf_cond) begin
      m_mdf = 1'b1;
      p_mdf = 1'b0;
    end else if (ctl_wr) begin
      if (p_mdf) m_mdf = 1'b0;
      p_mdf = 1'b0;
    end else if (sts_rd && m_mdf) p_mdf = 1'b1;
  endtask

  task automatic step(input bit rxd, input bit txl, input bit mf, input bit srd,
                      input bit cwr, input bit drd, input bit dwr);
    @(negedge clk);
    rx_done = rxd; tx_load = txl; mf_cond = mf;
    sts_rd = srd; ctl_wr = cwr; dat_rd = drd; dat_wr = dwr;
    #1;
    chk("R4 txe", txe, m_txe);
    chk("R2 rxf", rxf, m_rxf);
    chk("R3 ovr", ovr, m_ovr);
    chk("R5 mdf", mdf, m_mdf);
    chk("R7 irq_tx", irq_tx, exp_irq_tx());
    chk("R8 irq_rxerr", irq_rxerr, exp_irq_rxerr());
    model_tick();
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txe", txe, 1'b1);
    chk("R1 rxf", rxf, 1'b0);
    chk("R1 ovr", ovr, 1'b0);
    chk("R1 mdf", mdf, 1'b0);

    en_spi = 1'b1; ie_tx = 1'b1; ie_rx = 1'b1; ie_err = 1'b1;
    // R2: set, unarmed read ignored, armed read clears
    step(1, 0, 0, 0, 0, 0, 0); idle();
    chk("R2 set", rxf, 1'b1);
    step(0, 0, 0, 0, 0, 1, 0); idle();
    chk("R2 unarmed read", rxf, 1'b1);
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 1, 0); idle();
    chk("R2 sequence clear", rxf, 1'b0);
    // R3: overflow set and clear
    step(1, 0, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0, 0); idle();
    chk("R3 set", ovr, 1'b1);
    chk("R8 err irq", irq_rxerr, 1'b1);
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 1, 0); idle();
    chk("R3 clear", ovr, 1'b0);
    // R6: set beats a completed clear
    step(1, 0, 0, 0, 0, 0, 0); step(0, 0, 0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0, 1, 0); idle();
    chk("R6 rxf", rxf, 1'b1);
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 1, 0); idle();
    // R4 / R7
    step(0, 0, 0, 0, 0, 0, 1); idle();
    chk("R4 clear", txe, 1'b0);
    chk("R7 low", irq_tx, 1'b0);
    step(0, 1, 0, 0, 0, 0, 1); idle();
    chk("R6 txe", txe, 1'b1);
    chk("R7 high", irq_tx, 1'b1);
    en_spi = 1'b0; #1;
    chk("R7 disabled", irq_tx, 1'b0);
    // R8 independent of port enable
    step(1, 0, 0, 0, 0, 0, 0); idle();
    chk("R8 rx irq", irq_rxerr, 1'b1);
    ie_rx = 1'b0; #1;
    chk("R8 masked", irq_rxerr, 1'b0);
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 1, 0); idle();
    ie_rx = 1'b1; en_spi = 1'b1;
    // R5: fault in the middle of the sequence keeps the flag
    step(0, 0, 1, 0, 0, 0, 0); idle();
    chk("R5 set", mdf, 1'b1);
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0); idle();
    chk("R5 cancelled", mdf, 1'b1);
    step(0, 0, 0, 0, 1, 0, 0); idle();
    chk("R5 unarmed write", mdf, 1'b1);
    step(0, 0, 0, 1, 0, 0, 0); step(0, 0, 0, 0, 1, 0, 0); idle();
    chk("R5 clear", mdf, 1'b0);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if ((i % 64) == 0) begin
        r = $urandom;
        en_spi = r[0]; ie_tx = r[1]; ie_rx = r[2]; ie_err = r[3];
      end
      r = $urandom;
      step(r[1:0] == 2'b00, r[3:2] == 2'b00, r[8:4] == 5'd0, r[10:9] != 2'b00,
           r[12:11] == 2'b00, r[14:13] == 2'b00, r[16:15] == 2'b00);
    end
    idle();
    finish_run();
  end

endmodule